// File: doc/BRIEF.md
# Integer Execution Unit with One-Entry Reservation Station

This block is a single-cycle integer execution pipe for an out-of-order core. A dispatcher hands it one instruction at a time: a 4-bit operation code, the rename tag of the destination, and two source operands. Each source is either a finished value or the rename tag of a result that has not been produced yet. The instruction waits in a one-slot reservation station. The slot watches a result broadcast bus and takes any missing operand whose tag matches. It does this even when the broadcast arrives in the same cycle as the dispatch.

Once both operands are present and the output slot can take a result, the instruction issues. It goes to exactly one of three subunits: an adder/comparator, a logical unit, or a shift/rotate/count-leading-zeros unit. One cycle later the result, tagged with its destination, is offered on a valid/ready write port toward the rename buffers. The dispatch side is also valid/ready. A dispatch is taken on any clock edge where `d_valid` and `d_ready` are both high. While `d_ready` is low, the station ignores whatever is offered. On the result side, the result and its tag stay unchanged while `r_valid` is high and `r_ready` is low. During that time nothing else issues.

Top module: `iu_core`

## Requirements
- R1: After reset `r_valid` is 0 and `d_ready` is 1.
- R2: `d_ready` is high when the station is empty or when its held instruction issues in that same cycle. An offer made while `d_ready` is low is ignored and never produces a result.
- R3: An instruction dispatched with both operands ready appears on `r_valid` one clock after the dispatch edge, with `r_tag` equal to its destination tag. Back-to-back dispatches sustain one result per cycle.
- R4: A pending operand is filled only by a broadcast (`bc_valid`=1) whose `bc_tag` equals its tag. A broadcast with a different tag leaves it pending. The instruction does not issue until both operands are filled.
- R5: A broadcast whose tag matches a pending source in the same cycle that source is dispatched fills that source.
- R6: Arithmetic codes: 0 = a+b, 1 = a-b, both modulo 2^32.
- R7: Logical codes: 4 = a AND b, 5 = a OR b, 6 = a XOR b, 7 = NOT(a OR b).
- R8: Shift codes use b[4:0] as the amount: 8 = shift a left, 9 = logical shift right, 10 = arithmetic shift right, 11 = rotate a left.
- R9: Code 12 returns the number of leading zero bits of a. An all-zero a gives 32.
- R10: Compare codes 2 (signed) and 3 (unsigned) set `r_is_cond`=1, drive `r_data`=0, and return `r_cond` = {a<b, a>b, a==b, sum_ovf}, with bit 3 the less-than bit and bit 0 a copy of `sum_ovf` at issue. All other codes give `r_is_cond`=0.
- R11: While `r_valid`=1 and `r_ready`=0, `r_data`, `r_tag`, `r_cond` and `r_is_cond` hold, and no new instruction issues.
- R12: Each issue enables exactly one subunit, and no subunit is enabled in a cycle without an issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| d_valid | input | 1 | Dispatch offer valid |
| d_ready | output | 1 | Station can accept a dispatch |
| d_op | input | 4 | Operation code |
| d_tag | input | TAG_W | Destination rename tag |
| d_a_rdy | input | 1 | Source A carries a value |
| d_a_val | input | XLEN | Source A value |
| d_a_tag | input | TAG_W | Source A producer tag when pending |
| d_b_rdy | input | 1 | Source B carries a value |
| d_b_val | input | XLEN | Source B value |
| d_b_tag | input | TAG_W | Source B producer tag when pending |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Broadcast producer tag |
| bc_data | input | XLEN | Broadcast value |
| sum_ovf | input | 1 | Summary-overflow bit copied into compare results |
| r_valid | output | 1 | Result valid |
| r_ready | input | 1 | Rename buffer accepts the result |
| r_data | output | XLEN | Result value |
| r_tag | output | TAG_W | Destination tag of the result |
| r_cond | output | 4 | Compare condition field |
| r_is_cond | output | 1 | Result is a condition field |

## Verification
The bench builds the unit with its defaults, XLEN=32 and TAG_W=4. With 32 bits, the all-zero leading-zero count of 32 can be observed. An amount of 36 shows that only b[4:0] is used, and sign boundaries such as 0x7FFFFFFF+1 separate the signed and unsigned compares. Sixteen tags leave room for distinct destination, pending and decoy broadcast tags in each scenario, so a capture on the wrong tag would show up as an early or wrong result.

// File: rtl/iu_pkg.sv
package iu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMPS = 4'd2,
    OP_CMPU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10,
    OP_ROTL = 4'd11,
    OP_CLZ  = 4'd12
  } iu_op_e;

  localparam int UNIT_N   = 3;
  localparam int UNIT_ARI = 0;
  localparam int UNIT_LOG = 1;
  localparam int UNIT_ROT = 2;

  // one-hot steering of an operation code to its subunit
  function automatic logic [UNIT_N-1:0] unit_of(input iu_op_e op);
    logic [UNIT_N-1:0] sel;
    sel = '0;
    case (op)
      OP_ADD, OP_SUB, OP_CMPS, OP_CMPU:         sel[UNIT_ARI] = 1'b1;
      OP_SLL, OP_SRL, OP_SRA, OP_ROTL, OP_CLZ:  sel[UNIT_ROT] = 1'b1;
      default:                                  sel[UNIT_LOG] = 1'b1;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/iu_rstation.sv
module iu_rstation
  import iu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int TAG_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  drain,
  input  iu_op_e                ld_op,
  input  logic [TAG_W-1:0]      ld_dtag,
  input  logic [1:0]            ld_rdy,
  input  logic [1:0][XLEN-1:0]  ld_val,
  input  logic [1:0][TAG_W-1:0] ld_tag,
  input  logic                  bc_valid,
  input  logic [TAG_W-1:0]      bc_tag,
  input  logic [XLEN-1:0]       bc_data,
  output logic                  full,
  output iu_op_e                op,
  output logic [TAG_W-1:0]      dtag,
  output logic [1:0][XLEN-1:0]  opnd,
  output logic                  opnds_ready
);

  localparam int NSRC = 2;

  logic                  full_q;
  iu_op_e                op_q;
  logic [TAG_W-1:0]      dtag_q;
  logic [NSRC-1:0]       rdy_q;
  logic [1:0][XLEN-1:0]  val_q;
  logic [1:0][TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      op_q   <= OP_ADD;
      dtag_q <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      op_q   <= ld_op;
      dtag_q <= ld_dtag;
    end else if (drain) begin
      full_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic hit_ld;
    logic hit_held;
    assign hit_ld   = bc_valid && (bc_tag == ld_tag[g]);
    assign hit_held = bc_valid && (bc_tag == tag_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q[g] <= 1'b0;
        val_q[g] <= '0;
        tag_q[g] <= '0;
      end else if (load) begin
        // a broadcast in the dispatch cycle counts for the new entry
        rdy_q[g] <= ld_rdy[g] | hit_ld;
        val_q[g] <= ld_rdy[g] ? ld_val[g] : bc_data;
        tag_q[g] <= ld_tag[g];
      end else if (full_q && !rdy_q[g] && hit_held) begin
        rdy_q[g] <= 1'b1;
        val_q[g] <= bc_data;
      end
    end
  end

  assign full        = full_q;
  assign op          = op_q;
  assign dtag        = dtag_q;
  assign opnd        = val_q;
  assign opnds_ready = full_q && (&rdy_q);

endmodule

// File: rtl/iu_addcmp.sv
module iu_addcmp
  import iu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            en,
  input  iu_op_e          op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            so_in,
  output logic [XLEN-1:0] y,
  output logic [3:0]      cond,
  output logic            is_cond
);

  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] diff;
  logic            lt_s;
  logic            lt_u;
  logic            eq;

  assign sum  = a + b;
  assign diff = a - b;
  assign eq   = (a == b);
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;

  always_comb begin
    y       = '0;
    cond    = '0;
    is_cond = 1'b0;
    if (en) begin
      case (op)
        OP_ADD: y = sum;
        OP_SUB: y = diff;
        OP_CMPS: begin
          is_cond = 1'b1;
          cond    = {lt_s, !lt_s && !eq, eq, so_in};
        end
        OP_CMPU: begin
          is_cond = 1'b1;
          cond    = {lt_u, !lt_u && !eq, eq, so_in};
        end
        default: y = '0;
      endcase
    end
  end

endmodule

// File: rtl/iu_logic.sv
module iu_logic
  import iu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            en,
  input  iu_op_e          op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  always_comb begin
    y = '0;
    if (en) begin
      case (op)
        OP_AND:  y = a & b;
        OP_OR:   y = a | b;
        OP_XOR:  y = a ^ b;
        OP_NOR:  y = ~(a | b);
        default: y = '0;
      endcase
    end
  end

endmodule

// File: rtl/iu_rotclz.sv
module iu_rotclz
  import iu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                    en,
  input  iu_op_e                  op,
  input  logic [XLEN-1:0]         a,
  input  logic [$clog2(XLEN)-1:0] sh,
  output logic [XLEN-1:0]         y
);

  localparam int CNT_W = $clog2(XLEN) + 1;

  logic [2*XLEN-1:0] dbl;
  logic [CNT_W-1:0]  lz;

  assign dbl = {a, a} << sh;

  // highest set bit wins because it is visited last
  always_comb begin
    lz = CNT_W'(XLEN);
    for (int i = 0; i < XLEN; i++) begin
      if (a[i]) lz = CNT_W'(XLEN - 1 - i);
    end
  end

  always_comb begin
    y = '0;
    if (en) begin
      case (op)
        OP_SLL:  y = a << sh;
        OP_SRL:  y = a >> sh;
        OP_SRA:  y = $signed(a) >>> sh;
        OP_ROTL: y = dbl[2*XLEN-1:XLEN];
        OP_CLZ:  y = XLEN'(lz);
        default: y = '0;
      endcase
    end
  end

endmodule

// File: rtl/iu_core.sv
module iu_core
  import iu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  output logic             d_ready,
  input  logic [3:0]       d_op,
  input  logic [TAG_W-1:0] d_tag,
  input  logic             d_a_rdy,
  input  logic [XLEN-1:0]  d_a_val,
  input  logic [TAG_W-1:0] d_a_tag,
  input  logic             d_b_rdy,
  input  logic [XLEN-1:0]  d_b_val,
  input  logic [TAG_W-1:0] d_b_tag,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  input  logic [XLEN-1:0]  bc_data,
  input  logic             sum_ovf,
  output logic             r_valid,
  input  logic             r_ready,
  output logic [XLEN-1:0]  r_data,
  output logic [TAG_W-1:0] r_tag,
  output logic [3:0]       r_cond,
  output logic             r_is_cond
);

  localparam int SH_W = $clog2(XLEN);

  logic                  load;
  logic                  issue;
  logic                  full;
  logic                  opnds_ready;
  iu_op_e                op;
  logic [TAG_W-1:0]      dtag;
  logic [1:0][XLEN-1:0]  opnd;
  logic [UNIT_N-1:0]     unit_en;
  logic [XLEN-1:0]       y_ari;
  logic [XLEN-1:0]       y_log;
  logic [XLEN-1:0]       y_rot;
  logic [3:0]            cond_ari;
  logic                  is_cond_ari;

  assign issue   = opnds_ready && (!r_valid || r_ready);
  assign d_ready = !full || issue;
  assign load    = d_valid && d_ready;
  assign unit_en = issue ? unit_of(op) : '0;

  iu_rstation #(.XLEN(XLEN), .TAG_W(TAG_W)) u_rs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .drain      (issue),
    .ld_op      (iu_op_e'(d_op)),
    .ld_dtag    (d_tag),
    .ld_rdy     ({d_b_rdy, d_a_rdy}),
    .ld_val     ({d_b_val, d_a_val}),
    .ld_tag     ({d_b_tag, d_a_tag}),
    .bc_valid   (bc_valid),
    .bc_tag     (bc_tag),
    .bc_data    (bc_data),
    .full       (full),
    .op         (op),
    .dtag       (dtag),
    .opnd       (opnd),
    .opnds_ready(opnds_ready)
  );

  iu_addcmp #(.XLEN(XLEN)) u_ari (
    .en     (unit_en[UNIT_ARI]),
    .op     (op),
    .a      (opnd[0]),
    .b      (opnd[1]),
    .so_in  (sum_ovf),
    .y      (y_ari),
    .cond   (cond_ari),
    .is_cond(is_cond_ari)
  );

  iu_logic #(.XLEN(XLEN)) u_log (
    .en(unit_en[UNIT_LOG]),
    .op(op),
    .a (opnd[0]),
    .b (opnd[1]),
    .y (y_log)
  );

  iu_rotclz #(.XLEN(XLEN)) u_rot (
    .en(unit_en[UNIT_ROT]),
    .op(op),
    .a (opnd[0]),
    .sh(opnd[1][SH_W-1:0]),
    .y (y_rot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid   <= 1'b0;
      r_data    <= '0;
      r_tag     <= '0;
      r_cond    <= '0;
      r_is_cond <= 1'b0;
    end else if (issue) begin
      r_valid   <= 1'b1;
      r_data    <= y_ari | y_log | y_rot;
      r_tag     <= dtag;
      r_cond    <= cond_ari;
      r_is_cond <= is_cond_ari;
    end else if (r_ready) begin
      r_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/iu_core_chk.sv
module iu_core_chk #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             r_valid,
  input logic             r_ready,
  input logic [XLEN-1:0]  r_data,
  input logic [TAG_W-1:0] r_tag,
  input logic [3:0]       r_cond,
  input logic             r_is_cond,
  input logic [2:0]       unit_en,
  input logic             issue
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_tag) && $stable(r_cond) && $stable(r_is_cond))); // R11

  AST_ISSUE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (!r_valid || r_ready)); // R11

  AST_UNIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_en)); // R12

  AST_UNIT_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ($countones(unit_en) == 1)); // R12

  AST_IDLE_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> (unit_en == 3'b000)); // R12

  AST_COND_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_is_cond) |-> (r_data == '0)); // R10

endmodule

bind iu_core iu_core_chk #(.XLEN(XLEN), .TAG_W(TAG_W)) u_iu_core_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .r_valid  (r_valid),
  .r_ready  (r_ready),
  .r_data   (r_data),
  .r_tag    (r_tag),
  .r_cond   (r_cond),
  .r_is_cond(r_is_cond),
  .unit_en  (unit_en),
  .issue    (issue)
);

// File: tb/iu_core_bench.sv
`timescale 1ns/1ps
module iu_core_bench;

  localparam int XLEN  = 32;
  localparam int TAG_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             d_valid = 1'b0;
  logic             d_ready;
  logic [3:0]       d_op = '0;
  logic [TAG_W-1:0] d_tag = '0;
  logic             d_a_rdy = 1'b0;
  logic [XLEN-1:0]  d_a_val = '0;
  logic [TAG_W-1:0] d_a_tag = '0;
  logic             d_b_rdy = 1'b0;
  logic [XLEN-1:0]  d_b_val = '0;
  logic [TAG_W-1:0] d_b_tag = '0;
  logic             bc_valid = 1'b0;
  logic [TAG_W-1:0] bc_tag = '0;
  logic [XLEN-1:0]  bc_data = '0;
  logic             sum_ovf = 1'b0;
  logic             r_valid;
  logic             r_ready = 1'b1;
  logic [XLEN-1:0]  r_data;
  logic [TAG_W-1:0] r_tag;
  logic [3:0]       r_cond;
  logic             r_is_cond;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  iu_core #(.XLEN(XLEN), .TAG_W(TAG_W)) u_iu_core (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_disp(input logic [3:0] op, input logic [3:0] tag,
                            input logic ar, input logic [31:0] av, input logic [3:0] at,
                            input logic br, input logic [31:0] bv, input logic [3:0] bt);
    d_valid = 1'b1; d_op = op; d_tag = tag;
    d_a_rdy = ar; d_a_val = av; d_a_tag = at;
    d_b_rdy = br; d_b_val = bv; d_b_tag = bt;
  endtask

  // one dispatch; returns at the falling edge after the accepting edge
  task automatic send(input logic [3:0] op, input logic [3:0] tag,
                      input logic ar, input logic [31:0] av, input logic [3:0] at,
                      input logic br, input logic [31:0] bv, input logic [3:0] bt);
    @(negedge clk);
    drive_disp(op, tag, ar, av, at, br, bv, bt);
    @(negedge clk);
    d_valid = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic so, input logic [31:0] exp_d,
                        input logic [3:0] exp_c, input logic exp_is_c, input logic [3:0] tag);
    sum_ovf = so;
    send(op, tag, 1'b1, a, 4'h0, 1'b1, b, 4'h0);
    @(negedge clk);
    chk({req, " valid"}, {31'b0, r_valid}, 32'd1);
    chk({req, " data"}, r_data, exp_d);
    chk({req, " tag (R3)"}, {28'b0, r_tag}, {28'b0, tag});
    chk({req, " is_cond (R10)"}, {31'b0, r_is_cond}, {31'b0, exp_is_c});
    if (exp_is_c) chk({req, " cond"}, {28'b0, r_cond}, {28'b0, exp_c});
  endtask

  task automatic t_reset();
    chk("R1 r_valid", {31'b0, r_valid}, 32'd0);
    chk("R1 d_ready", {31'b0, d_ready}, 32'd1);
  endtask

  task automatic t_arith();
    run_op("R6 add wrap", 4'd0, 32'h7FFF_FFFF, 32'h1, 1'b0, 32'h8000_0000, 4'h0, 1'b0, 4'h1);
    run_op("R6 sub neg", 4'd1, 32'd5, 32'd7, 1'b0, 32'hFFFF_FFFE, 4'h0, 1'b0, 4'h2);
  endtask

  task automatic t_logic();
    run_op("R7 and", 4'd4, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b0, 32'h00F0_1234, 4'h0, 1'b0, 4'h3);
    run_op("R7 or",  4'd5, 32'hF000_0000, 32'h0000_000F, 1'b0, 32'hF000_000F, 4'h0, 1'b0, 4'h4);
    run_op("R7 xor", 4'd6, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 32'h5555_5555, 4'h0, 1'b0, 4'h5);
    run_op("R7 nor", 4'd7, 32'hFFFF_0000, 32'h0000_00FF, 1'b0, 32'h0000_FF00, 4'h0, 1'b0, 4'h6);
  endtask

  task automatic t_shift();
    run_op("R8 sll amt36", 4'd8, 32'h1, 32'h24, 1'b0, 32'h10, 4'h0, 1'b0, 4'h7);
    run_op("R8 srl", 4'd9, 32'h8000_0000, 32'd31, 1'b0, 32'h1, 4'h0, 1'b0, 4'h8);
    run_op("R8 sra", 4'd10, 32'h8000_0000, 32'd4, 1'b0, 32'hF800_0000, 4'h0, 1'b0, 4'h9);
    run_op("R8 rotl", 4'd11, 32'h8000_0001, 32'd4, 1'b0, 32'h0000_0018, 4'h0, 1'b0, 4'hA);
    run_op("R8 rotl0", 4'd11, 32'h1234_5678, 32'd32, 1'b0, 32'h1234_5678, 4'h0, 1'b0, 4'hB);
  endtask

  task automatic t_clz();
    run_op("R9 clz zero", 4'd12, 32'h0, 32'h0, 1'b0, 32'd32, 4'h0, 1'b0, 4'hC);
    run_op("R9 clz bit16", 4'd12, 32'h0001_0000, 32'h0, 1'b0, 32'd15, 4'h0, 1'b0, 4'hD);
    run_op("R9 clz msb", 4'd12, 32'h8000_0000, 32'h0, 1'b0, 32'd0, 4'h0, 1'b0, 4'hE);
  endtask

  task automatic t_compare();
    run_op("R10 cmp signed lt", 4'd2, 32'hFFFF_FFFF, 32'h1, 1'b0, 32'h0, 4'b1000, 1'b1, 4'h1);
    run_op("R10 cmp unsigned gt", 4'd3, 32'hFFFF_FFFF, 32'h1, 1'b0, 32'h0, 4'b0100, 1'b1, 4'h2);
    run_op("R10 cmp eq so", 4'd2, 32'h55, 32'h55, 1'b1, 32'h0, 4'b0011, 1'b1, 4'h3);
    sum_ovf = 1'b0;
  endtask

  task automatic bc_pulse(input logic [3:0] tag, input logic [31:0] data);
    bc_valid = 1'b1; bc_tag = tag; bc_data = data;
    @(negedge clk);
    bc_valid = 1'b0;
  endtask

  task automatic t_pending();
    // A waits on tag 5, B ready
    send(4'd0, 4'h9, 1'b0, 32'h0, 4'h5, 1'b1, 32'd10, 4'h0);
    @(negedge clk);
    chk("R4 no issue while pending", {31'b0, r_valid}, 32'd0);
    chk("R2 busy while held", {31'b0, d_ready}, 32'd0);
    bc_pulse(4'h6, 32'd999);
    @(negedge clk);
    chk("R4 wrong tag ignored", {31'b0, r_valid}, 32'd0);
    bc_pulse(4'h5, 32'd32);
    @(negedge clk);
    chk("R4 captured valid", {31'b0, r_valid}, 32'd1);
    chk("R4 captured data", r_data, 32'd42);
    chk("R4 tag", {28'b0, r_tag}, 32'h9);
  endtask

  task automatic t_both_pending();
    send(4'd1, 4'hA, 1'b0, 32'h0, 4'h1, 1'b0, 32'h0, 4'h2);
    bc_pulse(4'h2, 32'd3);
    @(negedge clk);
    chk("R4 one of two filled", {31'b0, r_valid}, 32'd0);
    bc_pulse(4'h1, 32'd10);
    @(negedge clk);
    chk("R4 both filled valid", {31'b0, r_valid}, 32'd1);
    chk("R4 both filled data", r_data, 32'd7);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    drive_disp(4'd5, 4'h4, 1'b1, 32'h0000_0F00, 4'h0, 1'b0, 32'h0, 4'h3);
    bc_valid = 1'b1; bc_tag = 4'h3; bc_data = 32'h0000_000F;
    @(negedge clk);
    d_valid = 1'b0; bc_valid = 1'b0;
    @(negedge clk);
    chk("R5 same-cycle capture valid", {31'b0, r_valid}, 32'd1);
    chk("R5 same-cycle capture data", r_data, 32'h0000_0F0F);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    r_ready = 1'b0;
    send(4'd0, 4'h1, 1'b1, 32'd1, 4'h0, 1'b1, 32'd1, 4'h0);
    @(negedge clk);
    chk("R11 first held valid", {31'b0, r_valid}, 32'd1);
    chk("R2 empty while output stalled", {31'b0, d_ready}, 32'd1);
    send(4'd0, 4'h2, 1'b1, 32'd2, 4'h0, 1'b1, 32'd2, 4'h0);
    @(negedge clk);
    chk("R11 data held", r_data, 32'd2);
    chk("R11 tag held", {28'b0, r_tag}, 32'h1);
    chk("R2 full blocks dispatch", {31'b0, d_ready}, 32'd0);
    // offer ignored while d_ready is low
    drive_disp(4'd0, 4'hF, 1'b1, 32'd100, 4'h0, 1'b1, 32'd100, 4'h0);
    @(negedge clk);
    d_valid = 1'b0;
    chk("R11 data still held", r_data, 32'd2);
    r_ready = 1'b1;
    @(negedge clk);
    chk("R11 second after release", r_data, 32'd4);
    chk("R11 second tag", {28'b0, r_tag}, 32'h2);
    @(negedge clk);
    chk("R2 ignored offer made no result", {31'b0, r_valid}, 32'd0);
  endtask

  task automatic t_stream();
    @(negedge clk);
    drive_disp(4'd6, 4'h3, 1'b1, 32'hFF, 4'h0, 1'b1, 32'h0F, 4'h0);
    @(negedge clk);
    chk("R2 ready while issuing", {31'b0, d_ready}, 32'd1);
    drive_disp(4'd8, 4'h4, 1'b1, 32'h3, 4'h0, 1'b1, 32'h2, 4'h0);
    @(negedge clk);
    d_valid = 1'b0;
    chk("R3 stream first", r_data, 32'hF0);
    chk("R3 stream first tag", {28'b0, r_tag}, 32'h3);
    @(negedge clk);
    chk("R3 stream second", r_data, 32'hC);
    chk("R3 stream second valid", {31'b0, r_valid}, 32'd1);
    @(negedge clk);
    chk("R3 stream drained", {31'b0, r_valid}, 32'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith();
    t_logic();
    t_shift();
    t_clz();
    t_compare();   // R12: each result comes from its one selected subunit
    t_pending();
    t_both_pending();
    t_same_cycle();
    t_backpressure();
    t_stream();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule